// File: doc/BRIEF.md
# Stream Write Receiver

This block is the card-side receiver for open-ended byte-stream writes. A start command carries a byte address, and from then on every byte offered on the data interface goes to the memory at the next address in turn. No length is given in advance and no CRC is carried. The write runs until a stop command arrives, and the stop reply carries every error flag gathered during the transfer.

The block checks each byte against the memory capacity, against a write-protected address window and against the memory's programming-busy signal. It handles the problems it finds in different ways. Bytes beyond the end of memory are dropped with no error. A write into the protected window, or a byte that arrives while the memory is still busy, aborts the stream: the block then ignores all further bytes until the stop. When partial writes are not allowed, a start or stop address that is not block-aligned raises an address error.

Top module: `stream_wr_rx`

## Requirements
- R1: After reset, `state_o` is 0 (idle), `status_o` is 0, and `mem_we` and `rsp_valid` are low.
- R2: `cmd_start` while idle, with an accepted address, moves `state_o` to 1 (receiving) and clears `status_o`. The first accepted byte is written to `cmd_addr`, and each later byte to the next address. `mem_we`, `mem_addr` and `mem_wdata` are valid in the cycle after the byte is offered.
- R3: With `partial_ok` low, a start address that is not a multiple of the block size (16 bytes by default) sets `status_o` bit 2 (address error) and moves `state_o` to 2 (discarding). No byte of that stream is written.
- R4: With `partial_ok` high, a stream may start and stop at any address, and no address error is raised.
- R5: `stop_req` while receiving or discarding produces a one-cycle `rsp_valid` pulse in the next cycle, with `rsp_status` = {address error, protect violation, overrun} (bits 2, 1, 0), and returns `state_o` to 0. `stop_req` while idle produces no reply. A byte offered in the same cycle as a stop is not written.
- R6: With `partial_ok` low, a stop whose next write address is not block-aligned sets bit 2 in the stop reply.
- R7: Bytes offered at or beyond address `mem_size` are dropped. They cause no write, set no status bit, and leave the block receiving.
- R8: A byte offered while `prog_busy` is high sets bit 0 (overrun) and moves the block to discarding. That byte and all later bytes until the stop are not written.
- R9: A byte whose address lies within [`wp_lo`, `wp_hi`] while `wp_en` is high sets bit 1 (protect violation) and moves the block to discarding. That byte and all later bytes until the stop are not written.
- R10: `cmd_start` while receiving is ignored, and the stream continues at its current address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Start-command strobe |
| cmd_addr | input | ADDR_W | Start byte address |
| byte_valid | input | 1 | Stream byte present |
| byte_data | input | 8 | Stream byte |
| stop_req | input | 1 | Stop-command strobe |
| partial_ok | input | 1 | Unaligned start and stop allowed |
| wp_en | input | 1 | Write-protect window enable |
| wp_lo | input | ADDR_W | First protected address |
| wp_hi | input | ADDR_W | Last protected address |
| mem_size | input | ADDR_W+1 | Memory capacity in bytes |
| prog_busy | input | 1 | Memory still programming previous byte |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | 8 | Memory write data |
| status_o | output | 3 | Accumulated errors {addr_err, wp_viol, overrun} |
| rsp_valid | output | 1 | Stop reply strobe |
| rsp_status | output | 3 | Error flags reported with the stop |
| state_o | output | 2 | 0 idle, 1 receiving, 2 discarding |

## Verification
The hardest case to reach is an error that arrives partway through a stream that is otherwise healthy. An example is a stream whose first bytes are written and whose next byte then lands in the protected window or meets a busy memory. After that point, the bench must see that the bytes already written stay written, while nothing later is written. The bench reaches this by starting streams a few bytes below the protected window and below the capacity limit, and by raising `prog_busy` only before the second byte. A scoreboard records which writes are expected, so any extra write after the abort shows up as a mismatch.

// File: rtl/stream_wr_pkg.sv
// Shared types for the stream write receiver.
// Assumes: the state encoding is visible at the top-level port state_o.
package stream_wr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_RECV    = 2'd1,
        ST_DISCARD = 2'd2
    } swr_state_e;

    typedef struct packed {
        logic addr_err;
        logic wp_viol;
        logic overrun;
    } swr_status_t;
endpackage

// File: rtl/swr_addr_check.sv
// Combinational address qualifiers: block alignment of the start and stop
// addresses, the end-of-memory test and the write-protect window hit.
// Assumes: cur_addr never exceeds mem_size (it only grows on accepted writes).
module swr_addr_check #(
    parameter int ADDR_W = 10,
    parameter int BLK_W  = 4
) (
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W:0]   cur_addr,
    input  logic [ADDR_W:0]   mem_size,
    input  logic              wp_en,
    input  logic [ADDR_W-1:0] wp_lo,
    input  logic [ADDR_W-1:0] wp_hi,
    input  logic              partial_ok,
    output logic              start_mis,
    output logic              stop_mis,
    output logic              past_end,
    output logic              in_wp
);
    generate
        if (BLK_W == 0) begin : g_byte_blk
            // Alignment check: single-byte blocks are always aligned.
            always_comb begin
                start_mis = 1'b0;
                stop_mis  = 1'b0;
            end
        end else begin : g_multi_blk
            // Alignment check: low address bits must be zero unless partial writes are allowed.
            always_comb begin
                start_mis = !partial_ok && (start_addr[BLK_W-1:0] != '0);
                stop_mis  = !partial_ok && (cur_addr[BLK_W-1:0] != '0);
            end
        end
    endgenerate

    // Range and protection tests on the current write address.
    always_comb begin
        past_end = (cur_addr >= mem_size);
        in_wp    = wp_en && (cur_addr[ADDR_W-1:0] >= wp_lo) && (cur_addr[ADDR_W-1:0] <= wp_hi);
    end
endmodule

// File: rtl/swr_ctrl.sv
// Stream receive controller: idle/receiving/discarding state, running write
// address, accumulated error flags and the stop reply.
// Assumes: address qualifiers come combinationally from swr_addr_check.
module swr_ctrl
    import stream_wr_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_valid,
    input  logic              stop_req,
    input  logic              prog_busy,
    input  logic              start_mis,
    input  logic              stop_mis,
    input  logic              past_end,
    input  logic              in_wp,
    output logic [ADDR_W:0]   cur_addr,
    output logic              accept,
    output swr_state_e        state,
    output swr_status_t       status,
    output logic              rsp_valid,
    output swr_status_t       rsp_status
);
    swr_state_e  state_d;
    swr_status_t stat_d;
    logic [ADDR_W:0] addr_d;
    logic        rsp_d;

    // Next-state, next-address and error-flag decision.
    always_comb begin
        state_d = state;
        stat_d  = status;
        addr_d  = cur_addr;
        accept  = 1'b0;
        rsp_d   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_start) begin
                    addr_d = {1'b0, cmd_addr};
                    stat_d = '0;
                    if (start_mis) begin
                        stat_d.addr_err = 1'b1;
                        state_d = ST_DISCARD;
                    end else begin
                        state_d = ST_RECV;
                    end
                end
            end
            ST_RECV: begin
                if (stop_req) begin
                    if (stop_mis) stat_d.addr_err = 1'b1;
                    rsp_d   = 1'b1;
                    state_d = ST_IDLE;
                end else if (byte_valid) begin
                    if (prog_busy) begin
                        stat_d.overrun = 1'b1;
                        state_d = ST_DISCARD;
                    end else if (past_end) begin
                        accept = 1'b0;
                    end else if (in_wp) begin
                        stat_d.wp_viol = 1'b1;
                        state_d = ST_DISCARD;
                    end else begin
                        accept = 1'b1;
                        addr_d = cur_addr + 1'b1;
                    end
                end
            end
            ST_DISCARD: begin
                if (stop_req) begin
                    rsp_d   = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State, address and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            status   <= '0;
            cur_addr <= '0;
        end else begin
            state    <= state_d;
            status   <= stat_d;
            cur_addr <= addr_d;
        end
    end

    // Stop reply register: one-cycle pulse carrying the final flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_status <= '0;
        end else begin
            rsp_valid <= rsp_d;
            if (rsp_d) rsp_status <= stat_d;
        end
    end
endmodule

// File: rtl/swr_wr_port.sv
// Memory write port: registers each accepted byte with its address.
// Assumes: accept is a single-cycle qualifier from the controller.
module swr_wr_port #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [7:0]        data_in,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata
);
    // Output register for the memory write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= accept;
            if (accept) begin
                mem_addr  <= addr_in;
                mem_wdata <= data_in;
            end
        end
    end
endmodule

// File: rtl/stream_wr_rx.sv
// Top of the stream write receiver. Accepts an open-ended byte stream after a
// start command and writes it to memory until a stop command.
// Assumes: strobes are single-cycle and synchronous to clk; mem_size <= 2**ADDR_W.
module stream_wr_rx
    import stream_wr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int BLK_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              stop_req,
    input  logic              partial_ok,
    input  logic              wp_en,
    input  logic [ADDR_W-1:0] wp_lo,
    input  logic [ADDR_W-1:0] wp_hi,
    input  logic [ADDR_W:0]   mem_size,
    input  logic              prog_busy,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic [2:0]        status_o,
    output logic              rsp_valid,
    output logic [2:0]        rsp_status,
    output logic [1:0]        state_o
);
    logic [ADDR_W:0] cur_addr;
    logic start_mis, stop_mis, past_end, in_wp, accept;
    swr_state_e  state;
    swr_status_t status, rsp_stat;

    swr_addr_check #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) chk_u (
        .start_addr(cmd_addr), .cur_addr(cur_addr), .mem_size(mem_size),
        .wp_en(wp_en), .wp_lo(wp_lo), .wp_hi(wp_hi), .partial_ok(partial_ok),
        .start_mis(start_mis), .stop_mis(stop_mis), .past_end(past_end), .in_wp(in_wp)
    );

    swr_ctrl #(.ADDR_W(ADDR_W)) ctrl_u (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .byte_valid(byte_valid), .stop_req(stop_req), .prog_busy(prog_busy),
        .start_mis(start_mis), .stop_mis(stop_mis), .past_end(past_end), .in_wp(in_wp),
        .cur_addr(cur_addr), .accept(accept), .state(state), .status(status),
        .rsp_valid(rsp_valid), .rsp_status(rsp_stat)
    );

    swr_wr_port #(.ADDR_W(ADDR_W)) port_u (
        .clk(clk), .rst_n(rst_n), .accept(accept), .addr_in(cur_addr[ADDR_W-1:0]),
        .data_in(byte_data), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
    );

    // Flatten internal types onto plain output ports.
    always_comb begin
        state_o    = state;
        status_o   = status;
        rsp_status = rsp_stat;
    end
endmodule

// File: rtl/swr_checker.sv
// Protocol checker for stream_wr_rx, attached by bind. Observes ports only.
module swr_checker #(
    parameter int ADDR_W = 10,
    parameter int BLK_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_start,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              byte_valid,
    input logic              stop_req,
    input logic              partial_ok,
    input logic              wp_en,
    input logic [ADDR_W-1:0] wp_lo,
    input logic [ADDR_W-1:0] wp_hi,
    input logic [ADDR_W:0]   mem_size,
    input logic              prog_busy,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [2:0]        status_o,
    input logic              rsp_valid,
    input logic [1:0]        state_o
);
    localparam int BLK = 1 << BLK_W;

    // R2: writes only follow a byte taken while receiving
    a_r2_write_from_recv: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($past(state_o) == 2'd1 && $past(byte_valid) && !$past(stop_req)));

    // R3: misaligned start without partial writes goes to discarding with address error
    a_r3_start_misaligned: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd0 && cmd_start && !partial_ok && (cmd_addr % BLK) != 0)
        |=> (state_o == 2'd2 && status_o[2]));

    // R5: a reply only follows a stop taken while active
    a_r5_reply_source: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(stop_req) && $past(state_o) != 2'd0));

    // R5: after a reply the block is idle
    a_r5_idle_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> state_o == 2'd0);

    // R7: no write at or past the capacity limit
    a_r7_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ({1'b0, mem_addr} < $past(mem_size)));

    // R8: a byte during busy aborts into discarding with overrun
    a_r8_overrun: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 2'd1 && byte_valid && prog_busy && !stop_req)
        |=> (state_o == 2'd2 && status_o[0]));

    // R8, R9: nothing is written while discarding
    a_r8_discard_silent: assert property (@(posedge clk) disable iff (!rst_n)
        state_o == 2'd2 |=> !mem_we);

    // R9: no write inside the protected window
    a_r9_no_wp_write: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !($past(wp_en) && mem_addr >= $past(wp_lo) && mem_addr <= $past(wp_hi)));
endmodule

bind stream_wr_rx swr_checker #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) swr_chk_i (
    .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
    .byte_valid(byte_valid), .stop_req(stop_req), .partial_ok(partial_ok),
    .wp_en(wp_en), .wp_lo(wp_lo), .wp_hi(wp_hi), .mem_size(mem_size),
    .prog_busy(prog_busy), .mem_we(mem_we), .mem_addr(mem_addr),
    .status_o(status_o), .rsp_valid(rsp_valid), .state_o(state_o)
);

// File: tb/stream_wr_rx_tb_top.sv
// Scoreboard bench for stream_wr_rx: driver tasks queue expected writes,
// a negedge monitor compares them against the memory write port.
module stream_wr_rx_tb_top;
    localparam int ADDR_W = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0;
    logic [ADDR_W-1:0] cmd_addr = '0;
    logic byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic stop_req = 1'b0;
    logic partial_ok = 1'b0;
    logic wp_en = 1'b0;
    logic [ADDR_W-1:0] wp_lo = '0;
    logic [ADDR_W-1:0] wp_hi = '0;
    logic [ADDR_W:0] mem_size = 11'd1024;
    logic prog_busy = 1'b0;
    logic mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [2:0] status_o;
    logic rsp_valid;
    logic [2:0] rsp_status;
    logic [1:0] state_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;
    logic [17:0] exp_q[$];

    always #5 clk = ~clk;

    stream_wr_rx #(.ADDR_W(ADDR_W), .BLK_W(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .byte_valid(byte_valid), .byte_data(byte_data), .stop_req(stop_req),
        .partial_ok(partial_ok), .wp_en(wp_en), .wp_lo(wp_lo), .wp_hi(wp_hi),
        .mem_size(mem_size), .prog_busy(prog_busy), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .status_o(status_o),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .state_o(state_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor: every write must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2 unexpected write actual=%0h expected=none", {mem_addr, mem_wdata});
            end else begin
                check("R2 write addr/data", {14'd0, mem_addr, mem_wdata}, {14'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic start_cmd(input int a);
        @(negedge clk);
        cmd_start = 1'b1; cmd_addr = a[ADDR_W-1:0];
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d, input bit wr, input int a);
        @(negedge clk);
        byte_valid = 1'b1; byte_data = d;
        if (wr) exp_q.push_back({a[ADDR_W-1:0], d});
        @(negedge clk);
        byte_valid = 1'b0;
    endtask

    task automatic stop_cmd(input string tag, input bit with_byte, input logic [2:0] exp_st);
        @(negedge clk);
        stop_req = 1'b1; byte_valid = with_byte; byte_data = 8'hEE;
        @(negedge clk);
        stop_req = 1'b0; byte_valid = 1'b0;
        check({tag, " reply valid"}, rsp_valid, 1);
        check({tag, " reply status"}, rsp_status, exp_st);
        check({tag, " idle after stop"}, state_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 state", state_o, 0);
        check("R1 status", status_o, 0);
        check("R1 mem_we", mem_we, 0);
        check("R1 rsp_valid", rsp_valid, 0);

        // R2 aligned stream of a full block, R5 clean stop
        start_cmd(16);
        check("R2 receiving", state_o, 1);
        for (int i = 0; i < 16; i++) send_byte(8'(8'h40 + i), 1, 16 + i);
        stop_cmd("R5", 0, 3'b000);

        // R3 misaligned start without partial writes
        start_cmd(5);
        check("R3 discarding", state_o, 2);
        check("R3 addr error flag", status_o, 3'b100);
        send_byte(8'h11, 0, 0);
        stop_cmd("R3", 0, 3'b100);

        // R4 partial writes: unaligned start and stop
        partial_ok = 1'b1;
        start_cmd(5);
        check("R4 receiving", state_o, 1);
        for (int i = 0; i < 3; i++) send_byte(8'(8'h20 + i), 1, 5 + i);
        stop_cmd("R4", 0, 3'b000);

        // R6 misaligned stop point without partial writes
        partial_ok = 1'b0;
        start_cmd(0);
        for (int i = 0; i < 3; i++) send_byte(8'(8'h30 + i), 1, i);
        stop_cmd("R6", 0, 3'b100);

        // R7 bytes past end of memory are dropped silently
        partial_ok = 1'b1; mem_size = 11'd40;
        start_cmd(36);
        for (int i = 0; i < 6; i++) send_byte(8'(8'h50 + i), i < 4, 36 + i);
        check("R7 still receiving", state_o, 1);
        check("R7 no status", status_o, 0);
        stop_cmd("R7", 0, 3'b000);
        mem_size = 11'd1024;

        // R8 overrun on busy memory
        start_cmd(0);
        send_byte(8'h61, 1, 0);
        prog_busy = 1'b1;
        send_byte(8'h62, 0, 0);
        prog_busy = 1'b0;
        check("R8 discarding", state_o, 2);
        check("R8 overrun flag", status_o, 3'b001);
        send_byte(8'h63, 0, 0);
        stop_cmd("R8", 0, 3'b001);

        // R9 write-protect violation mid-stream
        wp_en = 1'b1; wp_lo = 10'd48; wp_hi = 10'd55;
        start_cmd(46);
        send_byte(8'h71, 1, 46);
        send_byte(8'h72, 1, 47);
        send_byte(8'h73, 0, 48);
        check("R9 discarding", state_o, 2);
        check("R9 wp flag", status_o, 3'b010);
        send_byte(8'h74, 0, 0);
        stop_cmd("R9", 0, 3'b010);
        wp_en = 1'b0;

        // R10 start command ignored while receiving
        start_cmd(0);
        send_byte(8'h81, 1, 0);
        start_cmd(100);
        check("R10 still receiving", state_o, 1);
        send_byte(8'h82, 1, 1);
        // R5 byte in the same cycle as the stop is not written
        stop_cmd("R5 stop+byte", 1, 3'b000);

        // R5 stop while idle gives no reply
        @(negedge clk); stop_req = 1'b1;
        @(negedge clk); stop_req = 1'b0;
        check("R5 no reply when idle", rsp_valid, 0);
        check("R5 idle", state_o, 0);

        repeat (3) @(negedge clk);
        check("R2 all expected writes seen", exp_q.size(), 0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule